// File: doc/BRIEF.md
# Counter-Driven Three-State Sequencer

This block is a small control unit paired with its datapath. The datapath holds a binary counter and two one-bit flags: a tracking flag (E) and a done flag (F). A start pulse launches a counting run. During the run, the two upper counter bits are examined on every clock. They decide what the tracking flag becomes and whether the run ends. When the run ends, the done flag is raised and the unit goes back to idle.

The control unit has three states: idle, count and finish. Every action of a state happens on one clock edge: the increment, the flag update and the state change. Each of these actions uses the register values from before that edge. The stop decision is therefore taken from the counter value before it increments. The done flag rises one clock after the stop condition is seen.

With the default 4-bit counter and a run that starts from zero, the run ends with the counter at 1101, E at 1 and F at 1.

Top module: `cnt_seq_top`

## Requirements
- R1: While `rst` is high at a clock edge, the unit enters idle (state code 00). The same edge clears `cnt_a`, `flag_e`, `flag_f` and `busy`.
- R2: In idle with `start` low, a clock edge leaves `cnt_a`, `flag_e` and `flag_f` unchanged, and the unit stays in idle.
- R3: In idle with `start` high, a clock edge clears `cnt_a` and `flag_f`, leaves `flag_e` unchanged and enters the count state (code 01).
- R4: In the count state, every clock edge increments `cnt_a` by one.
- R5: In the count state, every clock edge loads `flag_e` with bit CNT_W-2 (bit 2 by default) of `cnt_a` as it was before that edge.
- R6: In the count state, a clock edge enters the finish state (code 11) when bits CNT_W-1 and CNT_W-2 of `cnt_a` are both 1 before the edge. Otherwise the unit stays in the count state.
- R7: In the finish state, a clock edge sets `flag_f` to 1, holds `cnt_a` and `flag_e`, and returns the unit to idle.
- R8: `start` has no effect while the unit is in the count or finish state.
- R9: `busy` is high exactly when `state_o` is not idle. `state_o` never takes the code 10.
- R10: With default parameters, a run launched from idle ends 15 clock edges after the start edge, counting the start edge itself. At that point `cnt_a` = 1101, `flag_e` = 1 and `flag_f` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launches a run when the unit is idle |
| cnt_a | output | CNT_W | Counter value |
| flag_e | output | 1 | Tracking flag |
| flag_f | output | 1 | Done flag |
| busy | output | 1 | High while the unit is not idle |
| state_o | output | 2 | State code: 00 idle, 01 count, 11 finish |

## Verification
The bound checker tests the single-step rules on every cycle:
- the increment and the tracking-flag load in the count state;
- the stop decision taken from the counter value before the edge;
- the finish-state actions, the idle hold and the launch;
- reset;
- the agreement between `busy` and the state code.

The whole-run outcome cannot be seen by the checker, because it depends on many steps in a row. This covers the final counter value of 1101, the run length of 15 edges, and the carry-over of the tracking flag from one run into the next. The bench's scenarios show these, together with a start held high through a run and a reset in the middle of counting.

// File: rtl/cnt_seq_pkg.sv
package cnt_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_COUNT  = 2'b01,
    ST_FINISH = 2'b11
  } seq_state_e;
endpackage

// File: rtl/cnt_seq_ctrl.sv
module cnt_seq_ctrl
  import cnt_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       sel_bit,
  input  logic       stop_bit,
  output seq_state_e state_q,
  output logic       busy_q,
  output logic       do_clear,
  output logic       do_count,
  output logic       do_finish
);
  seq_state_e state_d;

  // The stop decision uses counter bits from before the edge.
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start) state_d = ST_COUNT;
      ST_COUNT:  if (sel_bit && stop_bit) state_d = ST_FINISH;
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      busy_q  <= (state_d != ST_IDLE);
    end
  end

  always_comb begin
    do_clear  = (state_q == ST_IDLE) && start;
    do_count  = (state_q == ST_COUNT);
    do_finish = (state_q == ST_FINISH);
  end
endmodule

// File: rtl/cnt_seq_datapath.sv
module cnt_seq_datapath #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             do_clear,
  input  logic             do_count,
  input  logic             do_finish,
  output logic [CNT_W-1:0] cnt_q,
  output logic             e_q,
  output logic             f_q,
  output logic             sel_bit,
  output logic             stop_bit
);
  localparam int SEL_IDX  = CNT_W - 2;
  localparam int STOP_IDX = CNT_W - 1;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      e_q   <= 1'b0;
      f_q   <= 1'b0;
    end else if (do_clear) begin
      cnt_q <= '0;
      f_q   <= 1'b0;
    end else if (do_count) begin
      cnt_q <= cnt_q + ONE;
      e_q   <= cnt_q[SEL_IDX];
    end else if (do_finish) begin
      f_q   <= 1'b1;
    end
  end

  assign sel_bit  = cnt_q[SEL_IDX];
  assign stop_bit = cnt_q[STOP_IDX];
endmodule

// File: rtl/cnt_seq_top.sv
module cnt_seq_top
  import cnt_seq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic [CNT_W-1:0] cnt_a,
  output logic             flag_e,
  output logic             flag_f,
  output logic             busy,
  output logic [1:0]       state_o
);
  seq_state_e state_q;
  logic do_clear, do_count, do_finish, sel_bit, stop_bit;

  cnt_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .sel_bit   (sel_bit),
    .stop_bit  (stop_bit),
    .state_q   (state_q),
    .busy_q    (busy),
    .do_clear  (do_clear),
    .do_count  (do_count),
    .do_finish (do_finish)
  );

  cnt_seq_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .do_clear  (do_clear),
    .do_count  (do_count),
    .do_finish (do_finish),
    .cnt_q     (cnt_a),
    .e_q       (flag_e),
    .f_q       (flag_f),
    .sel_bit   (sel_bit),
    .stop_bit  (stop_bit)
  );

  assign state_o = state_q;
endmodule

// File: rtl/cnt_seq_chk.sv
module cnt_seq_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [CNT_W-1:0] cnt_a,
  input logic             flag_e,
  input logic             flag_f,
  input logic             busy,
  input logic [1:0]       state_o
);
  localparam logic [1:0] S_IDLE = 2'b00;
  localparam logic [1:0] S_CNT  = 2'b01;
  localparam logic [1:0] S_FIN  = 2'b11;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (state_o == S_IDLE && cnt_a == '0 && !flag_e && !flag_f && !busy));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == S_IDLE && !start) |=>
      (state_o == S_IDLE && $stable(cnt_a) && $stable(flag_e) && $stable(flag_f)));

  // R3
  launch_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == S_IDLE && start) |=>
      (state_o == S_CNT && cnt_a == '0 && !flag_f && flag_e == $past(flag_e)));

  // R4
  increment_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == S_CNT) |=> (cnt_a == $past(cnt_a) + ONE));

  // R5
  e_load_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == S_CNT) |=> (flag_e == $past(cnt_a[CNT_W-2])));

  // R6
  stop_seen_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == S_CNT && cnt_a[CNT_W-1] && cnt_a[CNT_W-2]) |=> (state_o == S_FIN));

  // R6
  keep_count_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == S_CNT && !(cnt_a[CNT_W-1] && cnt_a[CNT_W-2])) |=> (state_o == S_CNT));

  // R7
  finish_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == S_FIN) |=>
      (state_o == S_IDLE && flag_f && $stable(cnt_a) && $stable(flag_e)));

  // R9
  busy_match_chk: assert property (@(posedge clk) disable iff (rst)
    (busy == (state_o != S_IDLE)) && (state_o != 2'b10));
endmodule

bind cnt_seq_top cnt_seq_chk #(.CNT_W(CNT_W)) u_cnt_seq_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .cnt_a   (cnt_a),
  .flag_e  (flag_e),
  .flag_f  (flag_f),
  .busy    (busy),
  .state_o (state_o)
);

// File: tb/test_cnt_seq_top.sv
module test_cnt_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 4;
  localparam int WATCHDOG = 5000;

  typedef struct packed {
    logic [CNT_W-1:0] a;
    logic             e;
    logic             f;
    logic             busy;
    logic [1:0]       st;
  } snap_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [CNT_W-1:0] cnt_a;
  logic flag_e, flag_f, busy;
  logic [1:0] state_o;

  int checks = 0;
  int fails = 0;

  snap_t exp_q[$];
  string tag_q[$];

  // bench model of the visible registers
  logic [CNT_W-1:0] m_a = '0;
  logic m_e = 1'b0;
  logic m_f = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cnt_seq_top #(.CNT_W(CNT_W)) i_cnt_seq_top (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .cnt_a   (cnt_a),
    .flag_e  (flag_e),
    .flag_f  (flag_f),
    .busy    (busy),
    .state_o (state_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, expv, $time);
    end
  endtask

  task automatic push(input string tag, input logic [1:0] st);
    snap_t s;
    s.a = m_a; s.e = m_e; s.f = m_f; s.st = st; s.busy = (st != 2'b00);
    exp_q.push_back(s);
    tag_q.push_back(tag);
  endtask

  // monitor: compares one expected item per clock, away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        snap_t s;
        string t;
        s = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, "cnt_a", 32'(cnt_a), 32'(s.a));
        chk(t, "flag_e", 32'(flag_e), 32'(s.e));
        chk(t, "flag_f", 32'(flag_f), 32'(s.f));
        chk(t, "busy", 32'(busy), 32'(s.busy));
        chk(t, "state_o", 32'(state_o), 32'(s.st));
      end
    end
  end

  // idle for n edges with start low
  task automatic idle_seq(input int n);
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) push("R2", 2'b00);
    repeat (n) @(negedge clk);
  endtask

  // one complete run; hold keeps start high through count and finish (R8)
  task automatic run_seq(input bit hold);
    logic [CNT_W-1:0] v;
    int n;
    @(negedge clk);
    start = 1'b1;
    m_a = '0; m_f = 1'b0;
    push("R3", 2'b01);
    n = 1;
    v = '0;
    forever begin
      logic stop;
      stop = v[CNT_W-1] & v[CNT_W-2];
      m_e = v[CNT_W-2];
      m_a = v + 1'b1;
      push(hold ? "R8" : (stop ? "R6" : "R4/R5"), stop ? 2'b11 : 2'b01);
      n++;
      if (stop) break;
      v = v + 1'b1;
    end
    m_f = 1'b1;
    push(hold ? "R8" : "R7", 2'b00);
    n++;
    @(negedge clk);
    if (!hold) start = 1'b0;
    repeat (n - 1) @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "cnt_a", 32'(cnt_a), 0);
    chk("R1", "flag_e", 32'(flag_e), 0);
    chk("R1", "flag_f", 32'(flag_f), 0);
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "state_o", 32'(state_o), 0);
    rst = 1'b0;

    idle_seq(3);
    run_seq(1'b0);
    // R10: whole-run outcome
    chk("R10", "final cnt_a", 32'(cnt_a), 32'h0000000d);
    chk("R10", "final flag_e", 32'(flag_e), 1);
    chk("R10", "final flag_f", 32'(flag_f), 1);
    idle_seq(4);
    run_seq(1'b1);
    idle_seq(2);

    // reset in the middle of a count run
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R1", "mid-run cnt_a", 32'(cnt_a), 0);
    chk("R1", "mid-run flag_e", 32'(flag_e), 0);
    chk("R1", "mid-run flag_f", 32'(flag_f), 0);
    chk("R1", "mid-run busy", 32'(busy), 0);
    chk("R1", "mid-run state_o", 32'(state_o), 0);
    @(negedge clk);
    rst = 1'b0;
    m_a = '0; m_e = 1'b0; m_f = 1'b0;
    idle_seq(2);
    run_seq(1'b0);
    idle_seq(2);
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule